// File: doc/BRIEF.md
# Immediate-Shift Second-Operand Generator

This block forms the second operand of a data-processing operation from a register value and a 12-bit operand field. The field carries a 5-bit shift count, a 2-bit shift kind and a 4-bit source register index. The block applies the chosen shift to the 32-bit value and produces a shifter carry. When a flag-update enable is asserted, that carry is sent out. When the enable is low, the incoming carry is passed through unchanged.

A count of zero does not always mean "no shift". For logical left it does. Logical right and arithmetic right with a count of zero act as shifts by the full word width. Rotate with a count of zero becomes a one-bit rotate through the carry, making a 33-bit loop. The block is purely combinational and holds no state.

The source register index is decoded and brought out so the surrounding datapath can select the register. Reading the register file, register-specified shift counts, the ALU and the flag register all sit outside this block.

Top module: `barrel_operand`

## Requirements
- R1: Field positions in `enc_i`: shift count is bits [11:7], shift kind is bits [6:5], and bits [3:0] appear unchanged on `src_idx_o`. Shift kind codes are 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right.
- R2: Logical left with count n in 1..31 gives `operand_i << n` and shifter carry `operand_i[32-n]`. With count 0 it passes the operand through unchanged, and the shifter carry is `carry_i`.
- R3: Logical right with count n in 1..31 gives `operand_i >> n` with zero fill and shifter carry `operand_i[n-1]`.
- R4: Logical right with count 0 gives an all-zero result and shifter carry `operand_i[31]`.
- R5: Arithmetic right with count n in 1..31 fills the vacated upper bits with `operand_i[31]`; the shifter carry is `operand_i[n-1]`.
- R6: Arithmetic right with count 0 sets every result bit to `operand_i[31]`; the shifter carry is `operand_i[31]`.
- R7: Rotate right with count n in 1..31 rotates the operand right by n places; the shifter carry is result bit 31.
- R8: Rotate right with count 0 gives `{carry_i, operand_i[31:1]}` and shifter carry `operand_i[0]`.
- R9: `carry_o` equals the shifter carry when `flag_en_i` is 1, and equals `carry_i` for every shift kind and count when `flag_en_i` is 0. `flag_en_i` does not alter `result_o`.
- R10: Bit 4 of `enc_i` has no effect on `result_o`, `carry_o` or `src_idx_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Register value to be shifted |
| carry_i | input | 1 | Incoming carry flag |
| enc_i | input | 12 | Operand field: count, kind, register index |
| flag_en_i | input | 1 | Select shifter carry (1) or incoming carry (0) |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Carry to the flag logic |
| src_idx_o | output | 4 | Decoded source register index |

## Verification
The block has no state, so a wrong decode or a faulty shift path shows on `result_o` or `carry_o` in the same cycle as the input that triggers it. The riskiest parts are the count-zero reinterpretations and the carry bit chosen at the edges of the count range, such as n = 1 and n = 31. Every kind and count combination is therefore applied with several operands and with both carry values. A fault that mixes up the kind of shift or the count-zero handling changes at least one output bit on the first vector that reaches it.

// File: rtl/barrel_operand_pkg.sv
package barrel_operand_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = $clog2(DATA_W);
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned ENC_W  = 12;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic [AMT_W-1:0] amt;
    shift_kind_e      kind;
    logic [IDX_W-1:0] idx;
  } op_field_t;
endpackage

// File: rtl/shift_field_dec.sv
module shift_field_dec
  import barrel_operand_pkg::*;
(
  input  logic [AMT_W-1:0] amt_bits_i,
  input  logic [1:0]       kind_bits_i,
  input  logic [IDX_W-1:0] idx_bits_i,
  output op_field_t        field_o
);
  always_comb begin
    field_o.amt  = amt_bits_i;
    field_o.kind = shift_kind_e'(kind_bits_i);
    field_o.idx  = idx_bits_i;
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import barrel_operand_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  op_i,
  input  logic          cin_i,
  input  logic [AW-1:0] amt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  res_o,
  output logic          cout_o
);
  localparam int unsigned EW = AW + 1;

  logic          amt_zero;
  logic [EW-1:0] eff;      // count zero means full width for right shifts
  logic [AW-1:0] tap_rt;   // last bit shifted out to the right
  logic [AW-1:0] tap_lt;   // last bit shifted out to the left
  logic [EW-1:0] ror_back;
  logic [W-1:0]  ror_res;

  assign amt_zero = (amt_i == '0);
  assign eff      = amt_zero ? EW'(W) : {1'b0, amt_i};
  assign tap_rt   = AW'(int'(eff) - 1);
  assign tap_lt   = AW'(int'(W) - int'(amt_i));
  assign ror_back = EW'(int'(W) - int'(amt_i));
  assign ror_res  = (op_i >> amt_i) | (op_i << ror_back);

  always_comb begin
    res_o  = op_i;
    cout_o = cin_i;
    unique case (kind_i)
      SH_LSL: begin
        res_o  = op_i << amt_i;
        cout_o = amt_zero ? cin_i : op_i[tap_lt];
      end
      SH_LSR: begin
        res_o  = op_i >> eff;
        cout_o = op_i[tap_rt];
      end
      SH_ASR: begin
        res_o  = W'($signed(op_i) >>> eff);
        cout_o = op_i[tap_rt];
      end
      SH_ROR: begin
        if (amt_zero) begin
          res_o  = {cin_i, op_i[W-1:1]};
          cout_o = op_i[0];
        end else begin
          res_o  = ror_res;
          cout_o = ror_res[W-1];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/carry_sel.sv
module carry_sel (
  input  logic flag_en_i,
  input  logic shift_c_i,
  input  logic carry_i,
  output logic carry_o
);
  assign carry_o = flag_en_i ? shift_c_i : carry_i;
endmodule

// File: rtl/barrel_operand.sv
module barrel_operand
  import barrel_operand_pkg::*;
(
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  input  logic [ENC_W-1:0]  enc_i,
  input  logic              flag_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic [IDX_W-1:0]  src_idx_o
);
  op_field_t fld;
  logic      shift_c;
  logic      unused_enc_b4;

  assign unused_enc_b4 = enc_i[4];

  shift_field_dec u_dec (
    .amt_bits_i  (enc_i[11:7]),
    .kind_bits_i (enc_i[6:5]),
    .idx_bits_i  (enc_i[3:0]),
    .field_o     (fld)
  );

  shift_core #(.W(DATA_W), .AW(AMT_W)) u_core (
    .op_i   (operand_i),
    .cin_i  (carry_i),
    .amt_i  (fld.amt),
    .kind_i (fld.kind),
    .res_o  (result_o),
    .cout_o (shift_c)
  );

  carry_sel u_csel (
    .flag_en_i (flag_en_i),
    .shift_c_i (shift_c),
    .carry_i   (carry_i),
    .carry_o   (carry_o)
  );

  assign src_idx_o = fld.idx;
endmodule

// File: rtl/barrel_operand_chk.sv
module barrel_operand_chk (
  input logic [31:0] operand_i,
  input logic        carry_i,
  input logic [11:0] enc_i,
  input logic        flag_en_i,
  input logic [31:0] result_o,
  input logic        carry_o,
  input logic [3:0]  src_idx_o
);
  logic       unused_chk_b4;
  logic [4:0] a;
  logic [1:0] k;
  assign unused_chk_b4 = enc_i[4];
  assign a = enc_i[11:7];
  assign k = enc_i[6:5];

  always_comb begin
    // R1
    idx_pass_chk: assert (src_idx_o == enc_i[3:0]);
    // R2
    lsl_zero_chk: assert (!(k == 2'd0 && a == 5'd0) || result_o == operand_i);
    // R4
    lsr_full_chk: assert (!(k == 2'd1 && a == 5'd0) || result_o == 32'd0);
    // R6
    asr_full_chk: assert (!(k == 2'd2 && a == 5'd0) || result_o == {32{operand_i[31]}});
    // R8
    rrx_chk: assert (!(k == 2'd3 && a == 5'd0) || result_o == {carry_i, operand_i[31:1]});
    // R7
    ror_carry_chk: assert (!(k == 2'd3 && a != 5'd0 && flag_en_i) || carry_o == result_o[31]);
    // R9
    keep_carry_chk: assert (flag_en_i || carry_o == carry_i);
  end
endmodule

bind barrel_operand barrel_operand_chk u_chk (
  .operand_i (operand_i),
  .carry_i   (carry_i),
  .enc_i     (enc_i),
  .flag_en_i (flag_en_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .src_idx_o (src_idx_o)
);

// File: tb/barrel_operand_test.sv
module barrel_operand_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] operand_i = '0;
  logic        carry_i = 1'b0;
  logic [11:0] enc_i = '0;
  logic        flag_en_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  logic [3:0]  src_idx_o;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  barrel_operand uut (
    .operand_i (operand_i),
    .carry_i   (carry_i),
    .enc_i     (enc_i),
    .flag_en_i (flag_en_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .src_idx_o (src_idx_o)
  );

  // Behavioural reference: returns {shifter_carry, result}
  function automatic logic [32:0] ref_shift(input logic [31:0] op, input logic cin,
                                            input int amt, input int kind);
    logic [31:0] r = '0;
    logic c = cin;
    int n = (amt == 0) ? 32 : amt;
    case (kind)
      0: if (amt == 0) r = op;
         else begin
           for (int i = 0; i < 32; i++) r[i] = (i >= amt) ? op[i-amt] : 1'b0;
           c = op[32-amt];
         end
      1: begin
           for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? op[i+n] : 1'b0;
           c = op[n-1];
         end
      2: begin
           for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? op[i+n] : op[31];
           c = op[n-1];
         end
      default: if (amt == 0) begin
           for (int i = 0; i < 31; i++) r[i] = op[i+1];
           r[31] = cin;
           c = op[0];
         end else begin
           for (int i = 0; i < 32; i++) r[i] = op[(i + amt) % 32];
           c = r[31];
         end
    endcase
    return {c, r};
  endfunction

  function automatic string tag_of(input int amt, input int kind);
    case (kind)
      0: return "R2";
      1: return (amt == 0) ? "R4" : "R3";
      2: return (amt == 0) ? "R6" : "R5";
      default: return (amt == 0) ? "R8" : "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] op, input logic cin, input int amt,
                       input int kind, input logic b4, input logic fen, input logic [3:0] idx);
    @(posedge clk); #1;
    operand_i = op;
    carry_i   = cin;
    enc_i     = {5'(amt), 2'(kind), b4, idx};
    flag_en_i = fen;
  endtask

  task automatic vec(input logic [31:0] op, input logic cin, input int amt,
                     input int kind, input logic fen);
    logic [32:0] e;
    logic [3:0] idx = 4'($urandom);
    apply(op, cin, amt, kind, 1'b0, fen, idx);
    e = ref_shift(op, cin, amt, kind);
    @(negedge clk);
    chk(tag_of(amt, kind), result_o, e[31:0]);
    if (fen) chk(tag_of(amt, kind), {31'd0, carry_o}, {31'd0, e[32]});
    else begin
      chk("R9", {31'd0, carry_o}, {31'd0, cin});   // R9 carry held
      chk("R9", result_o, e[31:0]);                // R9 result unaffected
    end
    chk("R1", {28'd0, src_idx_o}, {28'd0, idx});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (!done && cycles > 150000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hFFFF_FFFF;
    pats[3] = 32'h0000_0000; pats[4] = 32'hA5C3_3C5A; pats[5] = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R1: idle inputs give zero outputs
    @(negedge clk);
    chk("R1", result_o, 32'd0);
    chk("R1", {31'd0, carry_o}, 32'd0);
    chk("R1", {28'd0, src_idx_o}, 32'd0);
    // Every kind/count combination
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++) begin
        for (int p = 0; p < 6; p++) begin
          vec(pats[p], 1'b0, a, k, 1'b1);
          vec(pats[p], 1'b1, a, k, 1'b1);
        end
        for (int r = 0; r < 4; r++) vec($urandom, 1'($urandom), a, k, 1'b1);
        vec($urandom, 1'b1, a, k, 1'b0);
        vec($urandom, 1'b0, a, k, 1'b0);
      end
    // R10: bit 4 has no effect
    for (int t = 0; t < 64; t++) begin
      logic [31:0] op = $urandom;
      logic cin = 1'($urandom);
      logic fen = 1'($urandom);
      int a = $urandom_range(0, 31);
      int k = $urandom_range(0, 3);
      logic [3:0] idx = 4'($urandom);
      logic [31:0] r0;
      logic c0;
      logic [3:0] i0;
      apply(op, cin, a, k, 1'b0, fen, idx);
      @(negedge clk);
      r0 = result_o; c0 = carry_o; i0 = src_idx_o;
      apply(op, cin, a, k, 1'b1, fen, idx);
      @(negedge clk);
      chk("R10", result_o, r0);
      chk("R10", {31'd0, carry_o}, {31'd0, c0});
      chk("R10", {28'd0, src_idx_o}, {28'd0, i0});
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule